// File: doc/BRIEF.md
# Fetch-Side Program Trace Reporter

This block sits beside the instruction fetch stage of a small processor core. It turns the fetch stage's event strobes into trace output that an external debug tool can use to rebuild program flow. Every clock it reports what kind of fetch was last issued, or that no fetch was issued. It also reports how many already-fetched instructions the pipeline cancelled on that clock, so the tool can discard squashed instructions. Trace is taken at fetch time rather than at retirement.

Some fetches follow an indirect flow change: a branch whose target comes from the link or count register, return from interrupt, a write to the machine state register, or any interrupt or exception. These fetches carry a trace-cycle attribute. A synchronized level input, `vsyncIn`, decides whether such fetches must be forced onto the external bus even when an internal memory would supply the data. Each rising or falling edge of `vsyncIn` arms a resynchronization. The next fetch of any kind is then marked as a trace cycle and is forced visible.

All outputs are registered. Inputs sampled at one rising clock edge appear on the outputs after that edge and hold for the following cycle.

Top module: `fetch_trace_reporter`

## Requirements
- R1: Status codes on `traceStatus` are 000 stall, 001 sequential, 010 branch not taken, 011 direct branch taken, 100 indirect flow change taken, and 101 interrupt/exception. Codes 110 and 111 never appear. During reset all outputs are zero.
- R2: When several fetch strobes are high in one cycle, the reported kind follows this priority: exception, then indirect, then direct, then not taken, then sequential.
- R3: When no fetch strobe is high, the next status is 000 (stall).
- R4: `cancelCount` reports the `cancelIn` value sampled at the same edge as the status. Values above 3 are reported as 3.
- R5: A fetch reported as indirect (100) or exception (101) raises `traceCycle`.
- R6: Sequential, not-taken and direct fetches leave `traceCycle` low, except for a resynchronizing fetch (R9).
- R7: While the synchronized VSYNC level is high, every fetch with `traceCycle` high also raises `forceExternal`.
- R8: While the synchronized VSYNC level is low, indirect and exception fetches do not raise `forceExternal`, except for a resynchronizing fetch.
- R9: After a rising edge of `vsyncIn` (two-flop synchronized), the first fetch of any kind raises both `traceCycle` and `forceExternal`. Later fetches do not.
- R10: A falling edge of `vsyncIn` arms the same resynchronization as a rising edge.
- R11: An armed resynchronization persists across stall cycles until a fetch is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchSeq | input | 1 | Sequential fetch issued |
| fetchNotTaken | input | 1 | Fetch after a branch not taken |
| fetchDirect | input | 1 | Fetch to a direct branch target |
| fetchIndirect | input | 1 | Fetch to an indirect flow change target (register branch, return from interrupt, state register write) |
| fetchExc | input | 1 | Fetch to an interrupt/exception vector |
| cancelIn | input | CANCEL_IN_W (3) | Instructions cancelled this cycle |
| vsyncIn | input | 1 | Asynchronous trace visibility request |
| traceStatus | output | 3 | Last fetch kind code |
| cancelCount | output | CNT_W (2) | Saturated cancel count |
| traceCycle | output | 1 | Program-trace-cycle attribute for the fetch |
| forceExternal | output | 1 | Force this fetch onto the external bus |

## Verification
A vector table drives single strobes, so each code and its trace attribute can be told apart. It then drives overlapping strobe sets, which separate a correct priority order from a wrong one. Cancel values in the table run from 0 to 7, which shows both pass-through and saturation.

Directed sequences hold VSYNC steady while strobes change, then toggle VSYNC in both directions across idle cycles. These sequences separate the resynchronization rule from the level-forcing rule. They also show that the arming survives stalls and is consumed by exactly one fetch.

// File: rtl/fetch_trace_pkg.sv
package fetch_trace_pkg;

  typedef enum logic [2:0] {
    KIND_STALL    = 3'd0,
    KIND_SEQ      = 3'd1,
    KIND_NOTTAKEN = 3'd2,
    KIND_DIRECT   = 3'd3,
    KIND_INDIRECT = 3'd4,
    KIND_EXC      = 3'd5
  } traceKind_e;

  typedef struct packed {
    traceKind_e kind;
    logic       fetchValid;
    logic       indirectFlow;
    logic       resync;
    logic       vsyncLevel;
  } ctrlStrobe_t;

endpackage

// File: rtl/ftr_control.sv
module ftr_control
  import fetch_trace_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fetchSeq,
  input  logic        fetchNotTaken,
  input  logic        fetchDirect,
  input  logic        fetchIndirect,
  input  logic        fetchExc,
  input  logic        vsyncIn,
  output ctrlStrobe_t strobe
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic vsyncPrev;
  logic pending;
  logic syncEdge;
  logic anyFetch;
  logic vsyncLvl;

  assign vsyncLvl = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
      vsyncPrev <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], vsyncIn};
      vsyncPrev <= vsyncLvl;
    end
  end

  assign syncEdge = vsyncLvl ^ vsyncPrev;
  assign anyFetch = fetchSeq | fetchNotTaken | fetchDirect | fetchIndirect | fetchExc;

  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= (pending | syncEdge) & ~anyFetch;
  end

  always_comb begin
    strobe = '0;
    strobe.fetchValid = anyFetch;
    strobe.vsyncLevel = vsyncLvl;
    strobe.resync     = anyFetch & (pending | syncEdge);
    if (fetchExc)           strobe.kind = KIND_EXC;
    else if (fetchIndirect) strobe.kind = KIND_INDIRECT;
    else if (fetchDirect)   strobe.kind = KIND_DIRECT;
    else if (fetchNotTaken) strobe.kind = KIND_NOTTAKEN;
    else if (fetchSeq)      strobe.kind = KIND_SEQ;
    else                    strobe.kind = KIND_STALL;
    strobe.indirectFlow = fetchExc | fetchIndirect;
  end

  // R11
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pending | syncEdge) && !anyFetch) |=> pending);

  // R9
  pending_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyFetch |=> !pending);

endmodule

// File: rtl/ftr_datapath.sv
module ftr_datapath
  import fetch_trace_pkg::*;
#(
  parameter int CANCEL_IN_W = 3,
  parameter int CNT_W       = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [CANCEL_IN_W-1:0] cancelIn,
  output logic [2:0]             traceStatus,
  output logic [CNT_W-1:0]       cancelCount,
  output logic                   traceCycle,
  output logic                   forceExternal
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam logic [CANCEL_IN_W-1:0] CNT_MAX_IN = CANCEL_IN_W'(CNT_MAX);

  logic [CNT_W-1:0] cancelSat;

  generate
    if (CANCEL_IN_W > CNT_W) begin : g_sat
      assign cancelSat = (cancelIn > CNT_MAX_IN) ? CNT_W'(CNT_MAX) : cancelIn[CNT_W-1:0];
    end else begin : g_pass
      assign cancelSat = CNT_W'(cancelIn);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      traceStatus   <= 3'd0;
      cancelCount   <= '0;
      traceCycle    <= 1'b0;
      forceExternal <= 1'b0;
    end else begin
      traceStatus   <= strobe.kind;
      cancelCount   <= cancelSat;
      traceCycle    <= strobe.indirectFlow | strobe.resync;
      forceExternal <= strobe.resync | (strobe.indirectFlow & strobe.vsyncLevel);
    end
  end

  // R1
  no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    traceStatus <= 3'd5);

  // R3
  stall_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fetchValid |=> traceStatus == 3'd0);

  // R4
  cancel_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(cancelIn) > CNT_MAX_IN) ? (cancelCount == CNT_W'(CNT_MAX))
                                             : (cancelCount == CNT_W'($past(cancelIn)))));

  // R7
  force_implies_trace_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceExternal |-> traceCycle);

endmodule

// File: rtl/fetch_trace_reporter.sv
module fetch_trace_reporter
  import fetch_trace_pkg::*;
#(
  parameter int CANCEL_IN_W = 3,
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fetchSeq,
  input  logic                   fetchNotTaken,
  input  logic                   fetchDirect,
  input  logic                   fetchIndirect,
  input  logic                   fetchExc,
  input  logic [CANCEL_IN_W-1:0] cancelIn,
  input  logic                   vsyncIn,
  output logic [2:0]             traceStatus,
  output logic [CNT_W-1:0]       cancelCount,
  output logic                   traceCycle,
  output logic                   forceExternal
);

  ctrlStrobe_t strobe;

  ftr_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .fetchSeq(fetchSeq), .fetchNotTaken(fetchNotTaken), .fetchDirect(fetchDirect),
    .fetchIndirect(fetchIndirect), .fetchExc(fetchExc),
    .vsyncIn(vsyncIn), .strobe(strobe)
  );

  ftr_datapath #(.CANCEL_IN_W(CANCEL_IN_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cancelIn(cancelIn),
    .traceStatus(traceStatus), .cancelCount(cancelCount),
    .traceCycle(traceCycle), .forceExternal(forceExternal)
  );

endmodule

// File: tb/tb_fetch_trace_reporter.sv
module tb_fetch_trace_reporter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] evt = 5'b0;   // {exc, indirect, direct, nottaken, seq}
  logic [2:0] cancelIn = 3'd0;
  logic vsyncIn = 1'b0;
  logic [2:0] traceStatus;
  logic [1:0] cancelCount;
  logic traceCycle, forceExternal;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fetch_trace_reporter dut (
    .clk(clk), .rstN(rstN),
    .fetchSeq(evt[0]), .fetchNotTaken(evt[1]), .fetchDirect(evt[2]),
    .fetchIndirect(evt[3]), .fetchExc(evt[4]),
    .cancelIn(cancelIn), .vsyncIn(vsyncIn),
    .traceStatus(traceStatus), .cancelCount(cancelCount),
    .traceCycle(traceCycle), .forceExternal(forceExternal)
  );

  // {evt[4:0], cancel[2:0], expStatus[2:0], expCancel[1:0], expTrace, expForce}
  localparam logic [14:0] VEC [11] = '{
    {5'b00001, 3'd0, 3'd1, 2'd0, 1'b0, 1'b0},  // R1 sequential
    {5'b00010, 3'd1, 3'd2, 2'd1, 1'b0, 1'b0},  // R1 R6 not taken
    {5'b00100, 3'd2, 3'd3, 2'd2, 1'b0, 1'b0},  // R1 R6 direct
    {5'b01000, 3'd3, 3'd4, 2'd3, 1'b1, 1'b0},  // R5 R8 indirect
    {5'b10000, 3'd7, 3'd5, 2'd3, 1'b1, 1'b0},  // R4 R5 exception, saturation
    {5'b11111, 3'd4, 3'd5, 2'd3, 1'b1, 1'b0},  // R2 all strobes
    {5'b01110, 3'd0, 3'd4, 2'd0, 1'b1, 1'b0},  // R2 indirect wins
    {5'b00111, 3'd5, 3'd3, 2'd3, 1'b0, 1'b0},  // R2 direct wins
    {5'b00011, 3'd1, 3'd2, 2'd1, 1'b0, 1'b0},  // R2 not taken wins
    {5'b00000, 3'd2, 3'd0, 2'd2, 1'b0, 1'b0},  // R3 stall
    {5'b00000, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0}   // R3 stall
  };

  task automatic check(input string req, input logic [2:0] st, input logic [1:0] cc,
                       input logic tc, input logic fe);
    checks++;
    if (traceStatus !== st || cancelCount !== cc || traceCycle !== tc || forceExternal !== fe) begin
      errors++;
      $display("FAIL %s: got st=%0d cc=%0d tc=%0b fe=%0b expected st=%0d cc=%0d tc=%0b fe=%0b",
               req, traceStatus, cancelCount, traceCycle, forceExternal, st, cc, tc, fe);
    end
  endtask

  // drive at negedge, sample at the next negedge (one register of latency)
  task automatic step(input string req, input logic [4:0] e, input logic [2:0] c, input logic vs,
                      input logic [2:0] st, input logic [1:0] cc, input logic tc, input logic fe);
    evt = e; cancelIn = c; vsyncIn = vs;
    @(posedge clk);
    @(negedge clk);
    check(req, st, cc, tc, fe);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    evt = 5'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", 3'd0, 2'd0, 1'b0, 1'b0);
    evt = 5'b01000; cancelIn = 3'd3;
    @(negedge clk);
    check("R1 reset holds", 3'd0, 2'd0, 1'b0, 1'b0);
    evt = 5'b0; cancelIn = 3'd0;
    rstN = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      step($sformatf("vector %0d", i), VEC[i][14:10], VEC[i][9:7], 1'b0,
           VEC[i][6:4], VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R9 R11: rising VSYNC, idle cycles keep the arming
    for (int k = 0; k < 4; k++) step("R11 idle after rise", 5'b0, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0, 1'b0);
    step("R9 resync seq", 5'b00001, 3'd0, 1'b1, 3'd1, 2'd0, 1'b1, 1'b1);
    step("R9 second seq plain", 5'b00001, 3'd0, 1'b1, 3'd1, 2'd0, 1'b0, 1'b0);
    step("R7 indirect forced", 5'b01000, 3'd1, 1'b1, 3'd4, 2'd1, 1'b1, 1'b1);
    step("R7 exception forced", 5'b10000, 3'd0, 1'b1, 3'd5, 2'd0, 1'b1, 1'b1);
    step("R6 direct not traced", 5'b00100, 3'd0, 1'b1, 3'd3, 2'd0, 1'b0, 1'b0);

    // R10: falling VSYNC
    for (int k = 0; k < 4; k++) step("R11 idle after fall", 5'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0);
    step("R10 resync direct", 5'b00100, 3'd0, 1'b0, 3'd3, 2'd0, 1'b1, 1'b1);
    step("R8 indirect unforced", 5'b01000, 3'd0, 1'b0, 3'd4, 2'd0, 1'b1, 1'b0);
    step("R6 not taken plain", 5'b00010, 3'd0, 1'b0, 3'd2, 2'd0, 1'b0, 1'b0);

    // R9: fetches issued while the edge propagates; only the first is resync
    evt = 5'b00001; vsyncIn = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 pre-sync seq", 3'd1, 2'd0, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R9 pre-sync seq 2", 3'd1, 2'd0, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R9 edge consumed", 3'd1, 2'd0, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R9 after consumed", 3'd1, 2'd0, 1'b0, 1'b0);
    evt = 5'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule